// File: doc/BRIEF.md
# High-Side Switch Source Selector

This block decides, for each of four high-side switch channels, whether the channel's gate is enabled. Each channel has its own 4-bit control code. The code picks the channel's source: held off, held on, one of four shared PWM waveforms, one of two shared timer waveforms, or a direct-drive input pin. All channels read the same shared waveforms through identical one-register paths. As a result, channels that hold the same code switch in the same clock cycle, and their outputs can be tied together to carry a larger load.

Supply over-voltage and under-voltage indications turn every channel off, unless a configuration bit disables that condition. A recovery bit sets what happens when the supply event ends. When the bit is 1, each channel goes back to its programmed source. When the bit is 0, each channel stays latched off until its control code is written again. The protection logic can force any channel's code to zero through a per-channel fault-clear request. Control codes are written one channel at a time and can all be read back at any time.

Top module: `hss_src_sel`

## Requirements
- R1: A write with `wr_en`=1 stores `wr_code` into channel `wr_ch`. The new code appears on `code_rd[4*ch+:4]` after the next clock edge. After reset, every code is 0000.
- R2: Code 0000 drives the channel off. Every code from 1001 to 1111 also drives the channel off.
- R3: Code 0001 drives the channel on constantly.
- R4: Codes 0010, 0011, 0100 and 0101 make the channel follow `pwm_in[0]`, `pwm_in[1]`, `pwm_in[2]` and `pwm_in[3]`. `gate_en` shows the value the source had one clock edge earlier.
- R5: Codes 0110 and 0111 make the channel follow `tmr_in[0]` and `tmr_in[1]`, with the same one-edge latency. This works on every channel, including channel index 3, which is the one used for cyclic wake sensing.
- R6: Code 1000 makes the channel follow `dir_in`. All channels that share any one code change `gate_en` on the same edge.
- R7: A `flt_clr_req[ch]` of 1 sets that channel's code to 0000 at the next edge. It takes priority over a write to the same channel in the same cycle.
- R8: While `sup_ov`=1 and `cfg_ov_dis`=0, every `gate_en` bit is 0 from the next edge onward. When `cfg_ov_dis`=1, `sup_ov` has no effect.
- R9: While `sup_uv`=1 and `cfg_uv_dis`=0, every `gate_en` bit is 0 from the next edge onward. When `cfg_uv_dis`=1, `sup_uv` has no effect.
- R10: With `cfg_rec`=1, once the supply event ends, each channel follows its programmed source again from the next edge. The stored codes are not changed by the event.
- R11: With `cfg_rec`=0, a supply event latches every channel off. A channel's latch is cleared by a write to that channel, even a write of the same code. The channel then resumes one edge after the write lands. Channels that are not written stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control code write strobe |
| wr_ch | input | 2 | Channel index for the write |
| wr_code | input | 4 | Code to store |
| flt_clr_req | input | 4 | Per-channel protection request that forces the code to 0000 |
| cfg_ov_dis | input | 1 | 1 = ignore supply over-voltage |
| cfg_uv_dis | input | 1 | 1 = ignore supply under-voltage |
| cfg_rec | input | 1 | 1 = restore the programmed state after a supply event |
| pwm_in | input | 4 | Shared PWM waveforms |
| tmr_in | input | 2 | Shared timer waveforms |
| dir_in | input | 1 | Direct-drive pin |
| sup_ov | input | 1 | Supply over-voltage indication |
| sup_uv | input | 1 | Supply under-voltage indication |
| code_rd | output | 16 | Readback of all four control codes, channel 0 in bits 3:0 |
| gate_en | output | 4 | Per-channel gate enable |

## Verification
Some rules are checked on every cycle. These are: a write landing in the code readback, a fault clear forcing zero, a zero code giving an off gate, enabled supply events turning all gates off, and channels on the direct code agreeing with each other. Other behaviour can only be shown by the bench's scenarios. This covers the mapping of every code to its source waveform, and that unused codes stay off. It also covers the difference between recovery on and recovery off after a supply event ends, and the per-channel release of the latched state on a rewrite.

// File: rtl/hss_pkg.sv
package hss_pkg;
  localparam int CODE_W   = 4;
  localparam int PWM_BASE = 2;
  localparam logic [CODE_W-1:0] CODE_OFF = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_ON  = 4'b0001;
  localparam logic [CODE_W-1:0] CODE_DIR = 4'b1000;
endpackage

// File: rtl/hss_code_bank.sv
module hss_code_bank
  import hss_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CHW-1:0]        wr_ch,
  input  logic [CODE_W-1:0]     wr_code,
  input  logic [NCH-1:0]        flt_clr_req,
  input  logic                  trip_now,
  input  logic                  latch_trip,
  output logic [NCH*CODE_W-1:0] codes,
  output logic [NCH-1:0]        tripped
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CHW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codes[c*CODE_W +: CODE_W] <= CODE_OFF;
      end else if (flt_clr_req[c]) begin
        codes[c*CODE_W +: CODE_W] <= CODE_OFF;
      end else if (hit) begin
        codes[c*CODE_W +: CODE_W] <= wr_code;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tripped[c] <= 1'b0;
      end else if (trip_now && latch_trip) begin
        tripped[c] <= 1'b1;
      end else if (hit) begin
        tripped[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hss_supply_gate.sv
module hss_supply_gate (
  input  logic sup_ov,
  input  logic sup_uv,
  input  logic cfg_ov_dis,
  input  logic cfg_uv_dis,
  input  logic cfg_rec,
  output logic trip_now,
  output logic latch_trip
);
  logic ov_act, uv_act;
  assign ov_act     = sup_ov && !cfg_ov_dis;
  assign uv_act     = sup_uv && !cfg_uv_dis;
  assign trip_now   = ov_act || uv_act;
  assign latch_trip = !cfg_rec;
endmodule

// File: rtl/hss_src_mux.sv
module hss_src_mux
  import hss_pkg::*;
#(
  parameter int NPWM = 4,
  parameter int NTMR = 2,
  localparam int TMR_BASE = PWM_BASE + NPWM
) (
  input  logic [CODE_W-1:0] code,
  input  logic [NPWM-1:0]   pwm_in,
  input  logic [NTMR-1:0]   tmr_in,
  input  logic              dir_in,
  output logic              sel
);
  always_comb begin
    sel = 1'b0;
    if (code == CODE_ON) sel = 1'b1;
    if (code == CODE_DIR) sel = dir_in;
    for (int k = 0; k < NPWM; k++)
      if (code == CODE_W'(PWM_BASE + k)) sel = pwm_in[k];
    for (int k = 0; k < NTMR; k++)
      if (code == CODE_W'(TMR_BASE + k)) sel = tmr_in[k];
  end
endmodule

// File: rtl/hss_src_sel.sv
module hss_src_sel
  import hss_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NPWM = 4,
  parameter int NTMR = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CHW-1:0]        wr_ch,
  input  logic [CODE_W-1:0]     wr_code,
  input  logic [NCH-1:0]        flt_clr_req,
  input  logic                  cfg_ov_dis,
  input  logic                  cfg_uv_dis,
  input  logic                  cfg_rec,
  input  logic [NPWM-1:0]       pwm_in,
  input  logic [NTMR-1:0]       tmr_in,
  input  logic                  dir_in,
  input  logic                  sup_ov,
  input  logic                  sup_uv,
  output logic [NCH*CODE_W-1:0] code_rd,
  output logic [NCH-1:0]        gate_en
);
  logic           trip_now, latch_trip;
  logic [NCH-1:0] tripped;
  logic [NCH-1:0] sel;

  hss_supply_gate u_sup (
    .sup_ov(sup_ov), .sup_uv(sup_uv),
    .cfg_ov_dis(cfg_ov_dis), .cfg_uv_dis(cfg_uv_dis), .cfg_rec(cfg_rec),
    .trip_now(trip_now), .latch_trip(latch_trip)
  );

  hss_code_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
    .flt_clr_req(flt_clr_req), .trip_now(trip_now), .latch_trip(latch_trip),
    .codes(code_rd), .tripped(tripped)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_mux
    hss_src_mux #(.NPWM(NPWM), .NTMR(NTMR)) u_mux (
      .code(code_rd[c*CODE_W +: CODE_W]), .pwm_in(pwm_in), .tmr_in(tmr_in),
      .dir_in(dir_in), .sel(sel[c])
    );
  end

  // Single shared register stage keeps every channel on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_en <= '0;
    else        gate_en <= (trip_now ? '0 : sel) & ~tripped;
  end
endmodule

// File: rtl/hss_src_sel_chk.sv
module hss_src_sel_chk #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [CHW-1:0]       wr_ch,
  input logic [3:0]           wr_code,
  input logic [NCH-1:0]       flt_clr_req,
  input logic                 cfg_ov_dis,
  input logic                 cfg_uv_dis,
  input logic                 sup_ov,
  input logic                 sup_uv,
  input logic [NCH*4-1:0]     code_rd,
  input logic [NCH-1:0]       gate_en
);
  p_ov_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ov && !cfg_ov_dis) |=> (gate_en == '0));
  p_uv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_uv && !cfg_uv_dis) |=> (gate_en == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ch == CHW'(c) && !flt_clr_req[c]) |=> (code_rd[c*4 +: 4] == $past(wr_code)));
    p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flt_clr_req[c] |=> (code_rd[c*4 +: 4] == 4'b0000));
    p_off_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (code_rd[c*4 +: 4] == 4'b0000) |=> !gate_en[c]);
  end

  p_dir_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_rd[3:0] == 4'b1000 && code_rd[7:4] == 4'b1000) |=> (gate_en[0] == gate_en[1]));
endmodule

bind hss_src_sel hss_src_sel_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
  .flt_clr_req(flt_clr_req), .cfg_ov_dis(cfg_ov_dis), .cfg_uv_dis(cfg_uv_dis),
  .sup_ov(sup_ov), .sup_uv(sup_uv), .code_rd(code_rd), .gate_en(gate_en)
);

// File: tb/test_hss_src_sel.sv
module test_hss_src_sel;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_ch = 0;
  logic [3:0]  wr_code = 0;
  logic [3:0]  flt_clr_req = 0;
  logic        cfg_ov_dis = 0, cfg_uv_dis = 0, cfg_rec = 1;
  logic [3:0]  pwm_in = 0;
  logic [1:0]  tmr_in = 0;
  logic        dir_in = 0;
  logic        sup_ov = 0, sup_uv = 0;
  logic [15:0] code_rd;
  logic [3:0]  gate_en;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hss_src_sel i_hss_src_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
    .flt_clr_req(flt_clr_req), .cfg_ov_dis(cfg_ov_dis), .cfg_uv_dis(cfg_uv_dis),
    .cfg_rec(cfg_rec), .pwm_in(pwm_in), .tmr_in(tmr_in), .dir_in(dir_in),
    .sup_ov(sup_ov), .sup_uv(sup_uv), .code_rd(code_rd), .gate_en(gate_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [3:0] code);
    wr_en = 1; wr_ch = 2'(ch); wr_code = code;
    step();
    wr_en = 0;
  endtask

  task automatic set_all(input logic [3:0] c0, c1, c2, c3);
    wr(0, c0); wr(1, c1); wr(2, c2); wr(3, c3);
  endtask

  task automatic t_reset();
    chk("R1 reset codes", code_rd, 0);
    chk("R1 reset gates", gate_en, 0);
  endtask

  task automatic t_write_read();
    set_all(4'h1, 4'h8, 4'hF, 4'h6);
    chk("R1 readback", code_rd, 16'h6F81);
  endtask

  task automatic t_const();
    pwm_in = 4'hF; tmr_in = 2'b11; dir_in = 1;
    set_all(4'h0, 4'h1, 4'h9, 4'hF);
    step();
    chk("R2 R3 off/on/unused", gate_en, 4'b0010);
    wr(2, 4'hC);
    step();
    chk("R2 unused code 1100", gate_en, 4'b0010);
  endtask

  task automatic t_pwm();
    set_all(4'h2, 4'h3, 4'h4, 4'h5);
    foreach (pwm_in[i]) begin end
    pwm_in = 4'b1010; step(); chk("R4 pwm pattern a", gate_en, 4'b1010);
    pwm_in = 4'b0101; step(); chk("R4 pwm pattern b", gate_en, 4'b0101);
    pwm_in = 4'b1100; step(); chk("R4 pwm pattern c", gate_en, 4'b1100);
    // swapped mapping
    set_all(4'h5, 4'h4, 4'h3, 4'h2);
    pwm_in = 4'b0001; step(); chk("R4 pwm reversed", gate_en, 4'b1000);
  endtask

  task automatic t_timer();
    set_all(4'h6, 4'h7, 4'h0, 4'h7);
    tmr_in = 2'b10; step(); chk("R5 timer ch3", gate_en, 4'b1010);
    tmr_in = 2'b01; step(); chk("R5 timer ch0", gate_en, 4'b0001);
  endtask

  task automatic t_direct();
    set_all(4'h8, 4'h8, 4'h8, 4'h8);
    dir_in = 1; step(); chk("R6 direct high lockstep", gate_en, 4'hF);
    dir_in = 0; step(); chk("R6 direct low lockstep", gate_en, 4'h0);
    set_all(4'h2, 4'h2, 4'h2, 4'h0);
    pwm_in = 4'b0001; step(); chk("R6 shared pwm lockstep", gate_en, 4'b0111);
  endtask

  task automatic t_fault();
    set_all(4'h1, 4'h1, 4'h1, 4'h1);
    flt_clr_req = 4'b0100;
    wr_en = 1; wr_ch = 2; wr_code = 4'h3;
    step();
    wr_en = 0; flt_clr_req = 0;
    chk("R7 clear beats write", code_rd, 16'h1011);
    step();
    chk("R7 cleared channel off", gate_en, 4'b1011);
  endtask

  task automatic t_ov();
    cfg_rec = 1;
    set_all(4'h1, 4'h1, 4'h1, 4'h1);
    step();
    sup_ov = 1; step(); chk("R8 ov forces off", gate_en, 4'h0);
    cfg_ov_dis = 1; step(); chk("R8 ov disabled no effect", gate_en, 4'hF);
    sup_ov = 0; cfg_ov_dis = 0; step();
    sup_uv = 1; step(); chk("R9 uv forces off", gate_en, 4'h0);
    cfg_uv_dis = 1; step(); chk("R9 uv disabled no effect", gate_en, 4'hF);
    sup_uv = 0; cfg_uv_dis = 0; step();
  endtask

  task automatic t_recover();
    cfg_rec = 1;
    set_all(4'h1, 4'h2, 4'h0, 4'h1);
    pwm_in = 4'b0001;
    sup_ov = 1; step(); chk("R10 off during event", gate_en, 4'h0);
    sup_ov = 0; step(); chk("R10 resumed", gate_en, 4'b1011);
    chk("R10 codes kept", code_rd, 16'h1021);
  endtask

  task automatic t_latch();
    cfg_rec = 0;
    set_all(4'h1, 4'h1, 4'h1, 4'h1);
    step();
    sup_uv = 1; step();
    sup_uv = 0; step(); chk("R11 stays off after event", gate_en, 4'h0);
    step(); chk("R11 still off", gate_en, 4'h0);
    wr(2, 4'h1);
    step(); chk("R11 rewritten channel resumes", gate_en, 4'b0100);
    cfg_rec = 1; step(); chk("R11 others still latched", gate_en, 4'b0100);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_write_read();
    t_const();
    t_pwm();
    t_timer();
    t_direct();
    t_fault();
    t_ov();
    t_recover();
    t_latch();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule